// File: doc/BRIEF.md
# Two-Phase Timestep Sequencer

This block is the control state machine for one timestep of a neuron-state engine. A single-cycle run pulse starts the timestep. The block first spends two cycles priming a two-deep read pipeline. It then waits for an upstream block to report that its own first phase is finished. After that it enters a scan phase. In the scan phase a row address walks the state memory and advances by one for every synapse packet that is accepted. When the packet for the last occupied row has been accepted, the block enters a second, data-driven phase. In that phase packets keep being accepted until an upstream source reports that it has nothing more to send. The block then returns to idle.

While idle, the sequencer can also serve single-word host accesses taken from a command queue. A read takes two cycles: a memory read, then a reply. A write also takes two cycles: a read that keeps the other half of the word, then the write itself. The block drives only strobes, flags, the scan address and a state code. The arithmetic on neuron state belongs to a separate datapath.

Top module: `timestep_sequencer`

## Requirements
- R1: While `rstN` is low the state code is 0, `phase1Done` and `phase2Done` are 1, `phase1Ready` is 0 and `scanAddr` is 0. One clock edge after `rstN` rises the state code is 1 (idle).
- R2: In idle, a high `runPulse` moves the block to state code 2 (fill). Fill lasts exactly two cycles with `fillRead` high, then the block enters state code 3 (wait). `runPulse` takes priority over a pending host command.
- R3: State 3 holds while `upPhase1Done` is low. When it is high the block enters state code 4 (scan) with `phase1Ready` = 1, `phase1Done` = 0, `phase2Done` = 0 and `scanAddr` = 0.
- R4: In state 4, `scanAddr` equals the number of packets accepted so far in this scan. A packet is accepted in a cycle where `pktPop` is high. The address is unchanged in cycles with no accepted packet.
- R5: The scan ends on the accepted packet taken while `scanAddr` equals the limit. The limit is max(ceil(`neuronCount`/32), 1) − 1, so the scan accepts limit+1 packets. The block then spends one cycle in state code 5 with `phase1Done` = 1 and `phase1Ready` = 1, and moves to state code 6 (directed).
- R6: `pktPop` equals `pktValid` in states 4 and 6, and is 0 in every other state.
- R7: State 6 holds while `upPhase2Finished` is low. When it is high the block enters state code 7 with `phase2Done` = 1 and `phase1Ready` = 0, then returns to idle on the next cycle.
- R8: In idle, with `cmdEmpty` low, `phase2Done` high, `runPulse` low and `cmdWrite` = 0, the block performs a host read. It goes to state code 8 with `hostRead` high, then to state code 9 with `hostReply` and `cmdPop` high, then back to idle.
- R9: The same condition with `cmdWrite` = 1 performs a host write. The block goes to state code 11 with `hostRead` high, then to state code 10 with `hostWrite` and `cmdPop` high, then back to idle.
- R10: A pending command (`cmdEmpty` low) outside idle has no effect. States 8 and 11 are entered only from idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| runPulse | input | 1 | Starts a timestep when in idle |
| upPhase1Done | input | 1 | Upstream first phase finished |
| upPhase2Finished | input | 1 | Upstream has no more directed packets |
| neuronCount | input | 17 | Number of neurons in use; sets the scan limit |
| pktValid | input | 1 | A synapse packet is available |
| pktPop | output | 1 | Accepts the current packet |
| cmdEmpty | input | 1 | Host command queue is empty |
| cmdWrite | input | 1 | Head command is a write (1) or a read (0) |
| cmdPop | output | 1 | Removes the head command |
| fillRead | output | 1 | Pipeline priming read strobe |
| hostRead | output | 1 | Host access memory read strobe |
| hostReply | output | 1 | Host read reply strobe |
| hostWrite | output | 1 | Host write strobe |
| phase1Ready | output | 1 | Scan phase active; spike flags meaningful while `phase1Done` is low |
| phase1Done | output | 1 | Scan phase complete |
| phase2Done | output | 1 | Directed phase complete |
| scanAddr | output | 12 | Current scan row |
| stateDbg | output | 4 | State code |

## Verification
A wrong state or a wrong fill counter shows at `stateDbg` on the very next cycle, and usually also at `pktPop` or one of the host strobes. This is because every output is decoded from the current state. A bad limit or a bad address counter does not show until the end of the scan, when the number of accepted packets differs from limit+1. To catch it early, the scan address is compared with the count of accepted packets on every cycle. A flag that is set or cleared on the wrong transition shows in the one cycle that states 5 and 7 last.

// File: rtl/tsq_pkg.sv
package tsq_pkg;

  typedef enum logic [3:0] {
    ST_RESET   = 4'd0,
    ST_IDLE    = 4'd1,
    ST_FILL    = 4'd2,
    ST_WAIT    = 4'd3,
    ST_SCAN    = 4'd4,
    ST_P1DONE  = 4'd5,
    ST_DIRECT  = 4'd6,
    ST_P2DONE  = 4'd7,
    ST_HRD_MEM = 4'd8,
    ST_HRD_RSP = 4'd9,
    ST_HWR_PUT = 4'd10,
    ST_HWR_GET = 4'd11
  } tsqState_e;

  typedef struct packed {
    logic clearAddr;
    logic stepAddr;
  } tsqStrobe_t;

endpackage

// File: rtl/tsq_scan_path.sv
module tsq_scan_path
  import tsq_pkg::*;
#(
  parameter int COUNT_W    = 17,
  parameter int LANE_SHIFT = 5
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  tsqStrobe_t                    strobe,
  input  logic [COUNT_W-1:0]            neuronCount,
  output logic [COUNT_W-LANE_SHIFT-1:0] scanAddr,
  output logic                          atLimit
);
  localparam int ROW_W  = COUNT_W - LANE_SHIFT;
  localparam int ROUND  = (1 << LANE_SHIFT) - 1;

  logic [COUNT_W:0]   paddedCount;
  logic [ROW_W:0]     rowsUsed;
  logic [ROW_W-1:0]   rowLimit;

  // Rows needed, rounded up; an empty count still scans one row.
  always_comb begin
    paddedCount = {1'b0, neuronCount} + (COUNT_W+1)'(ROUND);
    rowsUsed    = paddedCount[COUNT_W:LANE_SHIFT];
    if (rowsUsed == '0) rowLimit = '0;
    else                rowLimit = ROW_W'(rowsUsed - 1'b1);
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 scanAddr <= '0;
    else if (strobe.clearAddr) scanAddr <= '0;
    else if (strobe.stepAddr)  scanAddr <= scanAddr + 1'b1;
  end

  assign atLimit = (scanAddr == rowLimit);

endmodule

// File: rtl/tsq_control.sv
module tsq_control
  import tsq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       runPulse,
  input  logic       upPhase1Done,
  input  logic       upPhase2Finished,
  input  logic       pktValid,
  input  logic       cmdEmpty,
  input  logic       cmdWrite,
  input  logic       atLimit,
  output tsqStrobe_t strobe,
  output logic       pktPop,
  output logic       cmdPop,
  output logic       fillRead,
  output logic       hostRead,
  output logic       hostReply,
  output logic       hostWrite,
  output logic       phase1Ready,
  output logic       phase1Done,
  output logic       phase2Done,
  output tsqState_e  state
);
  tsqState_e nextState;
  logic      fillSecond;
  logic      startRun;
  logic      hostGo;

  assign startRun = (state == ST_IDLE) && runPulse;
  assign hostGo   = (state == ST_IDLE) && !runPulse && !cmdEmpty && phase2Done;

  always_comb begin
    nextState = state;
    unique case (state)
      ST_RESET:   nextState = ST_IDLE;
      ST_IDLE: begin
        if (startRun)    nextState = ST_FILL;
        else if (hostGo) nextState = cmdWrite ? ST_HWR_GET : ST_HRD_MEM;
      end
      ST_FILL:    if (fillSecond) nextState = ST_WAIT;
      ST_WAIT:    if (upPhase1Done) nextState = ST_SCAN;
      ST_SCAN:    if (pktValid && atLimit) nextState = ST_P1DONE;
      ST_P1DONE:  nextState = ST_DIRECT;
      ST_DIRECT:  if (upPhase2Finished) nextState = ST_P2DONE;
      ST_P2DONE:  nextState = ST_IDLE;
      ST_HRD_MEM: nextState = ST_HRD_RSP;
      ST_HRD_RSP: nextState = ST_IDLE;
      ST_HWR_GET: nextState = ST_HWR_PUT;
      ST_HWR_PUT: nextState = ST_IDLE;
      default:    nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= ST_RESET;
      fillSecond  <= 1'b0;
      phase1Ready <= 1'b0;
      phase1Done  <= 1'b1;
      phase2Done  <= 1'b1;
    end else begin
      state      <= nextState;
      fillSecond <= (state == ST_FILL) && !fillSecond;
      if (startRun) begin
        phase1Done <= 1'b0;
        phase2Done <= 1'b0;
      end
      if (state == ST_WAIT && upPhase1Done)
        phase1Ready <= 1'b1;
      if (state == ST_SCAN && pktValid && atLimit)
        phase1Done <= 1'b1;
      if (state == ST_DIRECT && upPhase2Finished) begin
        phase2Done  <= 1'b1;
        phase1Ready <= 1'b0;
      end
    end
  end

  always_comb begin
    strobe.clearAddr = startRun;
    strobe.stepAddr  = (state == ST_SCAN) && pktValid && !atLimit;
  end

  assign pktPop    = pktValid && (state == ST_SCAN || state == ST_DIRECT);
  assign fillRead  = (state == ST_FILL);
  assign hostRead  = (state == ST_HRD_MEM) || (state == ST_HWR_GET);
  assign hostReply = (state == ST_HRD_RSP);
  assign hostWrite = (state == ST_HWR_PUT);
  assign cmdPop    = (state == ST_HRD_RSP) || (state == ST_HWR_PUT);

endmodule

// File: rtl/timestep_sequencer.sv
module timestep_sequencer
  import tsq_pkg::*;
#(
  parameter int COUNT_W    = 17,
  parameter int LANE_SHIFT = 5
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          runPulse,
  input  logic                          upPhase1Done,
  input  logic                          upPhase2Finished,
  input  logic [COUNT_W-1:0]            neuronCount,
  input  logic                          pktValid,
  output logic                          pktPop,
  input  logic                          cmdEmpty,
  input  logic                          cmdWrite,
  output logic                          cmdPop,
  output logic                          fillRead,
  output logic                          hostRead,
  output logic                          hostReply,
  output logic                          hostWrite,
  output logic                          phase1Ready,
  output logic                          phase1Done,
  output logic                          phase2Done,
  output logic [COUNT_W-LANE_SHIFT-1:0] scanAddr,
  output logic [3:0]                    stateDbg
);
  tsqStrobe_t strobe;
  tsqState_e  state;
  logic       atLimit;

  tsq_control u_ctrl (
    .clk(clk), .rstN(rstN), .runPulse(runPulse),
    .upPhase1Done(upPhase1Done), .upPhase2Finished(upPhase2Finished),
    .pktValid(pktValid), .cmdEmpty(cmdEmpty), .cmdWrite(cmdWrite),
    .atLimit(atLimit), .strobe(strobe), .pktPop(pktPop), .cmdPop(cmdPop),
    .fillRead(fillRead), .hostRead(hostRead), .hostReply(hostReply),
    .hostWrite(hostWrite), .phase1Ready(phase1Ready),
    .phase1Done(phase1Done), .phase2Done(phase2Done), .state(state)
  );

  tsq_scan_path #(.COUNT_W(COUNT_W), .LANE_SHIFT(LANE_SHIFT)) u_path (
    .clk(clk), .rstN(rstN), .strobe(strobe), .neuronCount(neuronCount),
    .scanAddr(scanAddr), .atLimit(atLimit)
  );

  assign stateDbg = state;

endmodule

// File: rtl/tsq_checker.sv
module tsq_checker #(
  parameter int ROW_W = 12
) (
  input logic             clk,
  input logic             rstN,
  input logic             runPulse,
  input logic             upPhase1Done,
  input logic             upPhase2Finished,
  input logic             pktValid,
  input logic             pktPop,
  input logic             phase1Ready,
  input logic             phase1Done,
  input logic             phase2Done,
  input logic [ROW_W-1:0] scanAddr,
  input logic [3:0]       stateDbg
);
  a_r1_leave_reset: assert property (@(posedge clk) disable iff (!rstN)
    (stateDbg == 4'd0) |=> (stateDbg == 4'd1));

  a_r2_run_to_fill: assert property (@(posedge clk) disable iff (!rstN)
    (stateDbg == 4'd1 && runPulse) |=> (stateDbg == 4'd2));

  a_r2_fill_two: assert property (@(posedge clk) disable iff (!rstN)
    (stateDbg == 4'd2 && $past(stateDbg) == 4'd2) |=> (stateDbg == 4'd3));

  a_r3_wait_hold: assert property (@(posedge clk) disable iff (!rstN)
    (stateDbg == 4'd3 && !upPhase1Done) |=> (stateDbg == 4'd3));

  a_r4_addr_hold: assert property (@(posedge clk) disable iff (!rstN)
    (stateDbg == 4'd4 && !pktValid) |=> $stable(scanAddr));

  a_r4_addr_step: assert property (@(posedge clk) disable iff (!rstN)
    (stateDbg == 4'd4 && pktValid) |=>
      (stateDbg == 4'd5 || scanAddr == $past(scanAddr) + 1'b1));

  a_r5_phase1_flags: assert property (@(posedge clk) disable iff (!rstN)
    (stateDbg == 4'd5) |-> (phase1Done && phase1Ready));

  a_r6_pop_needs_valid: assert property (@(posedge clk) disable iff (!rstN)
    pktPop |-> pktValid);

  a_r6_no_pop_idle: assert property (@(posedge clk) disable iff (!rstN)
    (stateDbg == 4'd1 || stateDbg == 4'd3 || stateDbg == 4'd5) |-> !pktPop);

  a_r7_phase2_flags: assert property (@(posedge clk) disable iff (!rstN)
    (stateDbg == 4'd7) |-> (phase2Done && !phase1Ready));

  a_r7_back_idle: assert property (@(posedge clk) disable iff (!rstN)
    (stateDbg == 4'd7) |=> (stateDbg == 4'd1));

  a_r7_direct_hold: assert property (@(posedge clk) disable iff (!rstN)
    (stateDbg == 4'd6 && !upPhase2Finished) |=> (stateDbg == 4'd6));

  a_r8_read_seq: assert property (@(posedge clk) disable iff (!rstN)
    (stateDbg == 4'd8) |=> (stateDbg == 4'd9));

  a_r9_write_seq: assert property (@(posedge clk) disable iff (!rstN)
    (stateDbg == 4'd11) |=> (stateDbg == 4'd10));

  a_r10_host_from_idle: assert property (@(posedge clk) disable iff (!rstN)
    (stateDbg != 4'd1) |=> (stateDbg != 4'd8 && stateDbg != 4'd11));

endmodule

bind timestep_sequencer tsq_checker #(.ROW_W(COUNT_W - LANE_SHIFT)) u_tsqChk (
  .clk(clk), .rstN(rstN), .runPulse(runPulse), .upPhase1Done(upPhase1Done),
  .upPhase2Finished(upPhase2Finished), .pktValid(pktValid), .pktPop(pktPop),
  .phase1Ready(phase1Ready), .phase1Done(phase1Done), .phase2Done(phase2Done),
  .scanAddr(scanAddr), .stateDbg(stateDbg)
);

// File: tb/tb_timestep_sequencer.sv
`timescale 1ns/100ps
module tb_timestep_sequencer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        runPulse = 1'b0;
  logic        upPhase1Done = 1'b0;
  logic        upPhase2Finished = 1'b0;
  logic [16:0] neuronCount = '0;
  logic        pktValid = 1'b0;
  logic        pktPop;
  logic        cmdEmpty = 1'b1;
  logic        cmdWrite = 1'b0;
  logic        cmdPop, fillRead, hostRead, hostReply, hostWrite;
  logic        phase1Ready, phase1Done, phase2Done;
  logic [11:0] scanAddr;
  logic [3:0]  stateDbg;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  timestep_sequencer dut (
    .clk(clk), .rstN(rstN), .runPulse(runPulse), .upPhase1Done(upPhase1Done),
    .upPhase2Finished(upPhase2Finished), .neuronCount(neuronCount),
    .pktValid(pktValid), .pktPop(pktPop), .cmdEmpty(cmdEmpty),
    .cmdWrite(cmdWrite), .cmdPop(cmdPop), .fillRead(fillRead),
    .hostRead(hostRead), .hostReply(hostReply), .hostWrite(hostWrite),
    .phase1Ready(phase1Ready), .phase1Done(phase1Done),
    .phase2Done(phase2Done), .scanAddr(scanAddr), .stateDbg(stateDbg)
  );

  function automatic int limitOf(input int cnt);
    int rows = (cnt + 31) / 32;
    return (rows == 0) ? 0 : rows - 1;
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic runStep(input int cnt, input bit withCmd);
    int lim = limitOf(cnt);
    int pops = 0;
    int guard = 0;
    bit addrOk = 1'b1;
    int badAddr = 0;
    int badExp = 0;
    neuronCount = 17'(cnt);
    @(negedge clk);
    check(stateDbg == 4'd1, "R1 idle before run", stateDbg, 1);
    runPulse = 1'b1;
    if (withCmd) begin cmdEmpty = 1'b0; cmdWrite = 1'b1; end
    @(negedge clk);
    runPulse = 1'b0;
    check(stateDbg == 4'd2 && fillRead, "R2 fill first cycle", stateDbg, 2);
    @(negedge clk);
    check(stateDbg == 4'd2 && fillRead, "R2 fill second cycle", stateDbg, 2);
    @(negedge clk);
    check(stateDbg == 4'd3, "R2 wait after fill", stateDbg, 3);
    check(!phase1Done && !phase2Done, "R3 done flags cleared", {phase1Done, phase2Done}, 0);
    pktValid = 1'b1;
    for (int i = 0; i < 3; i++) begin
      #1;
      check(!pktPop, "R6 no pop while waiting", pktPop, 0);
      @(negedge clk);
      check(stateDbg == 4'd3, "R3 wait holds", stateDbg, 3);
    end
    upPhase1Done = 1'b1;
    @(negedge clk);
    upPhase1Done = 1'b0;
    check(stateDbg == 4'd4 && phase1Ready, "R3 scan entry ready", stateDbg, 4);
    check(scanAddr == 0, "R3 scan starts at row 0", scanAddr, 0);
    while (stateDbg == 4'd4 && guard < 5000) begin
      pktValid = ($urandom_range(0, 2) != 0);
      #1;
      if (scanAddr != 12'(pops) && addrOk) begin
        addrOk = 1'b0; badAddr = scanAddr; badExp = pops;
      end
      check(pktPop == pktValid, "R6 pop follows valid in scan", pktPop, pktValid);
      if (pktPop) pops++;
      @(negedge clk);
      guard++;
    end
    check(addrOk, "R4 scan address tracks accepted packets", badAddr, badExp);
    check(pops == lim + 1, "R5 accepted packets in scan", pops, lim + 1);
    check(stateDbg == 4'd5 && phase1Done && phase1Ready, "R5 phase1 done state", stateDbg, 5);
    pktValid = 1'b1;
    #1;
    check(!pktPop, "R6 no pop in phase1-done", pktPop, 0);
    @(negedge clk);
    check(stateDbg == 4'd6, "R5 directed follows", stateDbg, 6);
    for (int i = 0; i < 4; i++) begin
      pktValid = 1'(i & 1);
      #1;
      check(pktPop == pktValid, "R6 pop follows valid in directed", pktPop, pktValid);
      @(negedge clk);
      check(stateDbg == 4'd6, "R7 directed holds", stateDbg, 6);
    end
    pktValid = 1'b0;
    upPhase2Finished = 1'b1;
    @(negedge clk);
    upPhase2Finished = 1'b0;
    check(stateDbg == 4'd7 && phase2Done && !phase1Ready, "R7 phase2 done state", stateDbg, 7);
    check(withCmd == 1'b0 || !cmdPop, "R10 command untouched during timestep", cmdPop, 0);
    cmdEmpty = 1'b1;
    @(negedge clk);
    check(stateDbg == 4'd1, "R7 back to idle", stateDbg, 1);
  endtask

  task automatic hostOp(input bit isWrite);
    @(negedge clk);
    cmdEmpty = 1'b0;
    cmdWrite = isWrite;
    @(negedge clk);
    if (isWrite)
      check(stateDbg == 4'd11 && hostRead && !cmdPop, "R9 write read-step", stateDbg, 11);
    else
      check(stateDbg == 4'd8 && hostRead && !cmdPop, "R8 read memory-step", stateDbg, 8);
    @(negedge clk);
    cmdEmpty = 1'b1;
    if (isWrite)
      check(stateDbg == 4'd10 && hostWrite && cmdPop, "R9 write put-step", stateDbg, 10);
    else
      check(stateDbg == 4'd9 && hostReply && cmdPop, "R8 read reply-step", stateDbg, 9);
    @(negedge clk);
    check(stateDbg == 4'd1 && !cmdPop, isWrite ? "R9 idle after write" : "R8 idle after read", stateDbg, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    pktValid = 1'b1;
    repeat (3) @(negedge clk);
    check(stateDbg == 4'd0, "R1 reset state code", stateDbg, 0);
    check(phase1Done && phase2Done && !phase1Ready, "R1 reset flags", {phase1Done, phase2Done, phase1Ready}, 6);
    check(scanAddr == 0 && !pktPop, "R1 reset address and pop", scanAddr, 0);
    rstN = 1'b1;
    pktValid = 1'b0;
    @(negedge clk);
    check(stateDbg == 4'd1, "R1 idle after release", stateDbg, 1);

    hostOp(1'b0);
    hostOp(1'b1);
    runStep(0, 1'b0);
    runStep(1, 1'b0);
    runStep(32, 1'b1);
    runStep(33, 1'b0);
    hostOp(1'b1);
    for (int k = 0; k < 8; k++) begin
      runStep($urandom_range(0, 700), 1'(k & 1));
      if ($urandom_range(0, 1) != 0) hostOp(1'($urandom_range(0, 1)));
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule